// File: doc/BRIEF.md
# Width-Selectable Accumulator with Mode Flag

This block holds a 16-bit accumulator and an 8-bit processor status byte. Bit 5 of the status byte is the width flag. When the flag is 1, every width-aware accumulator operation works on the low byte only and leaves the upper byte as it was. When the flag is 0, those operations use the full 16 bits. The block accepts one operation per cycle, qualified by a single-cycle valid strobe. The operations are:

- clearing or setting status bits by mask;
- loading the whole status byte from a pulled value;
- loading, storing, logic, increment/decrement, shift and rotate on the accumulator;
- swapping the accumulator halves;
- full-width transfers into and out of the accumulator.

An emulation-mode input holds the width flag at 1. The flag can reach 0 only while that input is low (native mode). Every result appears one clock after the operation is issued. A second output reports the width that the operation used, so that a neighbouring datapath can size its memory access.

Top module: `wacc_core`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) sets the status to 0x34, which includes width flag bit 5 = 1. It also sets the accumulator to 0, `out_data` to 0 and `width_used` to 1.
- R2: The width flag is bit 5 of the status byte. Clear-by-mask (op code 1) clears every status bit whose `op_mask` bit is 1, so it clears the flag only when mask bit 5 is 1. Set-by-mask (op code 2) sets every status bit whose mask bit is 1.
- R3: Pull-status (op code 3) loads the whole status byte from `op_mask`, taking the flag from mask bit 5.
- R4: At every rising edge where `emu_mode` is 1, the width flag becomes 1. This overrides a clear by mask or by pull issued in the same cycle. The other status bits still follow that operation.
- R5: With the flag at 1, a width-aware accumulator write changes bits 7:0 only, and bits 15:8 keep their value. With the flag at 0, all 16 bits are written.
- R6: Width-aware writes set negative (status bit 7) from result bit 7 in 8-bit mode and from bit 15 in 16-bit mode. They set zero (status bit 1) when the active-width result is 0.
- R7: Shift and rotate operations work in the active width: shift-left (op code 11), shift-right (12), rotate-left (13), rotate-right (14). Carry (status bit 0) takes the bit shifted out. A rotate puts the old carry into bit 0, or into the top bit of the active width (bit 7 or bit 15).
- R8: The other width-aware operations each act on `op_data` or on the accumulator in the active width: load (op code 4), OR (6), AND (7), XOR (8), increment (9) and decrement (10). Each wraps within that width.
- R9: Store (op code 5) puts the accumulator on `out_data`. In 8-bit mode it sends the low byte with the upper byte as 0; in 16-bit mode it sends all 16 bits.
- R10: Half swap (op code 15), transfer-in from `op_data` (16) and transfer-out to `out_data` (17) always move all 16 bits, whatever the flag. None of them changes the status.
- R11: On every issued operation, `width_used` takes the flag value from before that operation. A flag change takes effect from the next operation.
- R12: With `op_valid` low, the accumulator, `out_data`, `width_used` and the status do not change. The one exception is the flag forcing of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Single-cycle operation strobe |
| op_code | input | 5 | Operation code (0 = no operation; unused codes do nothing) |
| op_mask | input | 8 | Bit mask for clear/set, or status byte for pull |
| op_data | input | 16 | Operand for load, logic operations and transfer-in |
| emu_mode | input | 1 | 1 = emulation mode, which holds the width flag at 1 |
| status | output | 8 | Processor status byte |
| acc | output | 16 | Full accumulator |
| out_data | output | 16 | Store or transfer-out result |
| width_used | output | 1 | Width flag sampled at issue of the last operation (1 = 8-bit) |

## Verification
Two update paths can act on the width flag in the same edge: an operation that writes it (clear by mask, or pull with bit 5 at 0) and emulation forcing. The bench provokes this by issuing each of those operations with `emu_mode` high. It judges the result by reading, one clock later, a status in which the flag is 1 while the other bits follow the operation. A second pairing issues a flag change and a width-aware load back to back. The bench then checks that `width_used` and the preserved upper byte show the old width for the flag-changing operation and the new width for the load.

// File: rtl/wacc_pkg.sv
// Package wacc_pkg
// Shared operation codes and op-class helpers for the width-selectable
// accumulator. Assumes a 5-bit operation code; unlisted codes act as no-op.
package wacc_pkg;

    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_CLR   = 5'd1,
        OP_SET   = 5'd2,
        OP_PULL  = 5'd3,
        OP_LOAD  = 5'd4,
        OP_STORE = 5'd5,
        OP_OR    = 5'd6,
        OP_AND   = 5'd7,
        OP_XOR   = 5'd8,
        OP_INC   = 5'd9,
        OP_DEC   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_ROTL  = 5'd13,
        OP_ROTR  = 5'd14,
        OP_SWAP  = 5'd15,
        OP_XIN   = 5'd16,
        OP_XOUT  = 5'd17
    } op_e;

    // True for operations whose accumulator write follows the width flag.
    function automatic logic op_sized_write(input op_e op);
        return op inside {OP_LOAD, OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC,
                          OP_SHL, OP_SHR, OP_ROTL, OP_ROTR};
    endfunction

    // True for operations that produce a carry.
    function automatic logic op_shifts(input op_e op);
        return op inside {OP_SHL, OP_SHR, OP_ROTL, OP_ROTR};
    endfunction

endpackage

// File: rtl/wacc_opunit.sv
// Module wacc_opunit
// Combinational result unit for one operand width. Computes the new value
// and carry-out of every width-aware operation. Assumes the caller picks
// the width variant; for non-arithmetic codes the operand passes through.
module wacc_opunit
    import wacc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_o
);

    // Result and carry selection for the issued operation.
    always_comb begin
        res_o = a_i;
        c_o   = c_i;
        case (op_i)
            OP_LOAD: res_o = d_i;
            OP_OR:   res_o = a_i | d_i;
            OP_AND:  res_o = a_i & d_i;
            OP_XOR:  res_o = a_i ^ d_i;
            OP_INC:  res_o = a_i + WIDTH'(1);
            OP_DEC:  res_o = a_i - WIDTH'(1);
            OP_SHL: begin
                res_o = {a_i[WIDTH-2:0], 1'b0};
                c_o   = a_i[WIDTH-1];
            end
            OP_SHR: begin
                res_o = {1'b0, a_i[WIDTH-1:1]};
                c_o   = a_i[0];
            end
            OP_ROTL: begin
                res_o = {a_i[WIDTH-2:0], c_i};
                c_o   = a_i[WIDTH-1];
            end
            OP_ROTR: begin
                res_o = {c_i, a_i[WIDTH-1:1]};
                c_o   = a_i[0];
            end
            default: begin
                res_o = a_i;
                c_o   = c_i;
            end
        endcase
    end

endmodule

// File: rtl/wacc_status.sv
// Module wacc_status
// Processor status byte. Applies mask clear/set, pull, and result flags
// (negative, zero, carry) on a valid operation. Holds the width flag at 1
// on every edge where emulation mode is high. Synchronous active-low reset.
module wacc_status
    import wacc_pkg::*;
#(
    parameter int                STAT_W    = 8,
    parameter int                MFLAG_BIT = 5,
    parameter int                CARRY_BIT = 0,
    parameter int                ZERO_BIT  = 1,
    parameter int                NEG_BIT   = 7,
    parameter logic [STAT_W-1:0] RESET_VAL = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  op_e               op_i,
    input  logic [STAT_W-1:0] mask_i,
    input  logic              emu_i,
    input  logic              n_i,
    input  logic              z_i,
    input  logic              c_i,
    output logic [STAT_W-1:0] status_o
);

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] status_d;

    // Next status: the operation's update first, then emulation forcing.
    always_comb begin
        status_d = status_q;
        if (op_valid_i) begin
            case (op_i)
                OP_CLR:  status_d = status_q & ~mask_i;
                OP_SET:  status_d = status_q | mask_i;
                OP_PULL: status_d = mask_i;
                default: begin
                    if (op_sized_write(op_i)) begin
                        status_d[NEG_BIT]  = n_i;
                        status_d[ZERO_BIT] = z_i;
                        if (op_shifts(op_i)) begin
                            status_d[CARRY_BIT] = c_i;
                        end
                    end
                end
            endcase
        end
        if (emu_i) begin
            status_d[MFLAG_BIT] = 1'b1;
        end
    end

    // Status register with synchronous reset to the emulation values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= RESET_VAL;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    // R4: emulation mode leaves the width flag set
    a_r4_emu_forces_flag: assert property (@(posedge clk) disable iff (!rst_n)
        emu_i |=> status_q[MFLAG_BIT]);

    // R2: clear-by-mask with bit 5 in native mode clears the flag
    a_r2_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_CLR && mask_i[MFLAG_BIT] && !emu_i)
        |=> !status_q[MFLAG_BIT]);

    // R2: set-by-mask with bit 5 sets the flag
    a_r2_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_SET && mask_i[MFLAG_BIT])
        |=> status_q[MFLAG_BIT]);

    // R12: idle cycles in native mode leave the status untouched
    a_r12_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i && !emu_i) |=> $stable(status_q));

endmodule

// File: rtl/wacc_accreg.sv
// Module wacc_accreg
// Accumulator, store/transfer output and width-used registers. Merges the
// narrow or wide result according to the width flag sampled at issue, so
// the upper byte is kept in 8-bit mode. Swap and transfers are always full
// width. Synchronous active-low reset.
module wacc_accreg
    import wacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  op_e               op_i,
    input  logic              narrow_i,
    input  logic [HALF_W-1:0] res_narrow_i,
    input  logic [DATA_W-1:0] res_wide_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] out_o,
    output logic              width_o
);

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] out_d;
    logic              width_q;

    // Next accumulator and output values for the issued operation.
    always_comb begin
        acc_d = acc_q;
        out_d = out_q;
        if (op_valid_i) begin
            if (op_sized_write(op_i)) begin
                acc_d = narrow_i ? {acc_q[DATA_W-1:HALF_W], res_narrow_i} : res_wide_i;
            end else begin
                case (op_i)
                    OP_SWAP:  acc_d = {acc_q[HALF_W-1:0], acc_q[DATA_W-1:HALF_W]};
                    OP_XIN:   acc_d = data_i;
                    OP_STORE: out_d = narrow_i ? {{(DATA_W-HALF_W){1'b0}}, acc_q[HALF_W-1:0]}
                                               : acc_q;
                    OP_XOUT:  out_d = acc_q;
                    default:  acc_d = acc_q;
                endcase
            end
        end
    end

    // Data registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            out_q   <= '0;
            width_q <= 1'b1;
        end else begin
            acc_q <= acc_d;
            out_q <= out_d;
            if (op_valid_i) begin
                width_q <= narrow_i;
            end
        end
    end

    assign acc_o   = acc_q;
    assign out_o   = out_q;
    assign width_o = width_q;

    // R5: a narrow write keeps the upper byte
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && narrow_i && op_sized_write(op_i))
        |=> $stable(acc_q[DATA_W-1:HALF_W]));

    // R10: half swap exchanges the two halves whatever the width
    a_r10_swap_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == OP_SWAP)
        |=> (acc_q[DATA_W-1:HALF_W] == $past(acc_q[HALF_W-1:0]))
            && (acc_q[HALF_W-1:0] == $past(acc_q[DATA_W-1:HALF_W])));

    // R12: idle cycles leave the data registers untouched
    a_r12_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> ($stable(acc_q) && $stable(out_q) && $stable(width_q)));

endmodule

// File: rtl/wacc_core.sv
// Module wacc_core
// Top of the width-selectable accumulator. Builds a narrow and a wide
// result unit in parallel and selects flags and result by the width flag
// held in the status register. Assumes one operation per valid strobe and
// that results are visible one clock after issue.
module wacc_core
    import wacc_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter int                STAT_W       = 8,
    parameter int                MFLAG_BIT    = 5,
    parameter int                CARRY_BIT    = 0,
    parameter int                ZERO_BIT     = 1,
    parameter int                NEG_BIT      = 7,
    parameter logic [STAT_W-1:0] RESET_STATUS = 8'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_code,
    input  logic [STAT_W-1:0] op_mask,
    input  logic [DATA_W-1:0] op_data,
    input  logic              emu_mode,
    output logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] out_data,
    output logic              width_used
);

    localparam int HALF_W = DATA_W / 2;

    op_e               op;
    logic              narrow;
    logic [HALF_W-1:0] res_narrow;
    logic [DATA_W-1:0] res_wide;
    logic [1:0]        var_c;
    logic              sel_n;
    logic              sel_z;
    logic              sel_c;

    assign op     = op_e'(op_code);
    assign narrow = status[MFLAG_BIT];

    // One result unit per operand width: variant 0 narrow, variant 1 wide.
    for (genvar v = 0; v < 2; v++) begin : g_var
        localparam int VW = (v == 0) ? HALF_W : DATA_W;
        logic [VW-1:0] r;
        wacc_opunit #(.WIDTH(VW)) u_op (
            .op_i  (op),
            .a_i   (acc[VW-1:0]),
            .d_i   (op_data[VW-1:0]),
            .c_i   (status[CARRY_BIT]),
            .res_o (r),
            .c_o   (var_c[v])
        );
        if (v == 0) begin : g_lo
            assign res_narrow = r;
        end else begin : g_hi
            assign res_wide = r;
        end
    end

    // Flag sources taken from the active-width result.
    always_comb begin
        if (narrow) begin
            sel_n = res_narrow[HALF_W-1];
            sel_z = (res_narrow == '0);
            sel_c = var_c[0];
        end else begin
            sel_n = res_wide[DATA_W-1];
            sel_z = (res_wide == '0);
            sel_c = var_c[1];
        end
    end

    wacc_status #(
        .STAT_W    (STAT_W),
        .MFLAG_BIT (MFLAG_BIT),
        .CARRY_BIT (CARRY_BIT),
        .ZERO_BIT  (ZERO_BIT),
        .NEG_BIT   (NEG_BIT),
        .RESET_VAL (RESET_STATUS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid_i (op_valid),
        .op_i       (op),
        .mask_i     (op_mask),
        .emu_i      (emu_mode),
        .n_i        (sel_n),
        .z_i        (sel_z),
        .c_i        (sel_c),
        .status_o   (status)
    );

    wacc_accreg #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_accreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid_i   (op_valid),
        .op_i         (op),
        .narrow_i     (narrow),
        .res_narrow_i (res_narrow),
        .res_wide_i   (res_wide),
        .data_i       (op_data),
        .acc_o        (acc),
        .out_o        (out_data),
        .width_o      (width_used)
    );

    // R11: the reported width is the flag before the issued operation
    a_r11_width_at_issue: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (width_used == $past(status[MFLAG_BIT])));

endmodule

// File: tb/wacc_core_tb.sv
`timescale 1ns/1ps
// Bench for wacc_core: a vector table walked by one loop, then directed
// tests for reset, idle cycles, emulation forcing and back-to-back width changes.
module wacc_core_tb_top;

    typedef struct packed {
        logic [3:0]  rq;
        logic [4:0]  op;
        logic [7:0]  mask;
        logic [15:0] data;
        logic        emu;
        logic [15:0] acc;
        logic [7:0]  st;
        logic        w;
        logic [15:0] out;
    } vec_t;

    localparam int NV = 29;
    // Vectors run in order from reset state: status 34, acc 0000, out 0000.
    localparam vec_t VECS [NV] = '{
        '{4'd2,  5'd1,  8'h20, 16'h0000, 1'b0, 16'h0000, 8'h14, 1'b1, 16'h0000}, // R2 clear flag
        '{4'd8,  5'd4,  8'h00, 16'h8001, 1'b0, 16'h8001, 8'h94, 1'b0, 16'h0000}, // R8 wide load
        '{4'd2,  5'd2,  8'h20, 16'h0000, 1'b0, 16'h8001, 8'hB4, 1'b0, 16'h0000}, // R2 set flag
        '{4'd5,  5'd4,  8'h00, 16'h1200, 1'b0, 16'h8000, 8'h36, 1'b1, 16'h0000}, // R5 narrow load keeps upper
        '{4'd8,  5'd9,  8'h00, 16'h0000, 1'b0, 16'h8001, 8'h34, 1'b1, 16'h0000}, // R8 narrow inc
        '{4'd9,  5'd5,  8'h00, 16'h0000, 1'b0, 16'h8001, 8'h34, 1'b1, 16'h0001}, // R9 narrow store
        '{4'd10, 5'd17, 8'h00, 16'h0000, 1'b0, 16'h8001, 8'h34, 1'b1, 16'h8001}, // R10 transfer out
        '{4'd10, 5'd15, 8'h00, 16'h0000, 1'b0, 16'h0180, 8'h34, 1'b1, 16'h8001}, // R10 swap
        '{4'd7,  5'd13, 8'h00, 16'h0000, 1'b0, 16'h0100, 8'h37, 1'b1, 16'h8001}, // R7 narrow rotl
        '{4'd7,  5'd14, 8'h00, 16'h0000, 1'b0, 16'h0180, 8'hB4, 1'b1, 16'h8001}, // R7 narrow rotr carry to bit 7
        '{4'd5,  5'd10, 8'h00, 16'h0000, 1'b0, 16'h017F, 8'h34, 1'b1, 16'h8001}, // R5 narrow dec
        '{4'd2,  5'd1,  8'h20, 16'h0000, 1'b0, 16'h017F, 8'h14, 1'b1, 16'h8001}, // R2 clear flag
        '{4'd8,  5'd10, 8'h00, 16'h0000, 1'b0, 16'h017E, 8'h14, 1'b0, 16'h8001}, // R8 wide dec
        '{4'd7,  5'd11, 8'h00, 16'h0000, 1'b0, 16'h02FC, 8'h14, 1'b0, 16'h8001}, // R7 wide shl
        '{4'd6,  5'd8,  8'h00, 16'h02FC, 1'b0, 16'h0000, 8'h16, 1'b0, 16'h8001}, // R6 wide zero
        '{4'd6,  5'd10, 8'h00, 16'h0000, 1'b0, 16'hFFFF, 8'h94, 1'b0, 16'h8001}, // R6 wide negative
        '{4'd7,  5'd12, 8'h00, 16'h0000, 1'b0, 16'h7FFF, 8'h15, 1'b0, 16'h8001}, // R7 wide shr
        '{4'd9,  5'd5,  8'h00, 16'h0000, 1'b0, 16'h7FFF, 8'h15, 1'b0, 16'h7FFF}, // R9 wide store
        '{4'd10, 5'd16, 8'h00, 16'hA5A5, 1'b0, 16'hA5A5, 8'h15, 1'b0, 16'h7FFF}, // R10 transfer in
        '{4'd3,  5'd3,  8'h20, 16'h0000, 1'b0, 16'hA5A5, 8'h20, 1'b0, 16'h7FFF}, // R3 pull sets flag
        '{4'd8,  5'd7,  8'h00, 16'h000F, 1'b0, 16'hA505, 8'h20, 1'b1, 16'h7FFF}, // R8 narrow and
        '{4'd6,  5'd6,  8'h00, 16'h0080, 1'b0, 16'hA585, 8'hA0, 1'b1, 16'h7FFF}, // R6 narrow negative
        '{4'd7,  5'd12, 8'h00, 16'h0000, 1'b0, 16'hA542, 8'h21, 1'b1, 16'h7FFF}, // R7 narrow shr
        '{4'd7,  5'd11, 8'h00, 16'h0000, 1'b0, 16'hA584, 8'hA0, 1'b1, 16'h7FFF}, // R7 narrow shl
        '{4'd3,  5'd3,  8'h00, 16'h0000, 1'b0, 16'hA584, 8'h00, 1'b1, 16'h7FFF}, // R3 pull clears flag
        '{4'd7,  5'd14, 8'h00, 16'h0000, 1'b0, 16'h52C2, 8'h00, 1'b0, 16'h7FFF}, // R7 wide rotr
        '{4'd7,  5'd13, 8'h00, 16'h0000, 1'b0, 16'hA584, 8'h80, 1'b0, 16'h7FFF}, // R7 wide rotl
        '{4'd4,  5'd1,  8'h20, 16'h0000, 1'b1, 16'hA584, 8'hA0, 1'b0, 16'h7FFF}, // R4 clear vs emulation
        '{4'd4,  5'd3,  8'h00, 16'h0000, 1'b1, 16'hA584, 8'h20, 1'b1, 16'h7FFF}  // R4 pull vs emulation
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = 5'd0;
    logic [7:0]  op_mask = 8'h00;
    logic [15:0] op_data = 16'h0000;
    logic        emu_mode = 1'b1;
    logic [7:0]  status;
    logic [15:0] acc;
    logic [15:0] out_data;
    logic        width_used;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wacc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_mask    (op_mask),
        .op_data    (op_data),
        .emu_mode   (emu_mode),
        .status     (status),
        .acc        (acc),
        .out_data   (out_data),
        .width_used (width_used)
    );

    task automatic chk(input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic chk_all(input string rq, input logic [15:0] ea, input logic [7:0] es,
                           input logic ew, input logic [15:0] eo);
        chk(rq, "acc", acc, ea);
        chk(rq, "status", {8'h00, status}, {8'h00, es});
        chk(rq, "width_used", {15'd0, width_used}, {15'd0, ew});
        chk(rq, "out_data", out_data, eo);
    endtask

    // Issue one operation at a falling edge; results are sampled at the next one.
    task automatic issue(input logic [4:0] op, input logic [7:0] m,
                         input logic [15:0] d, input logic e);
        op_valid = 1'b1;
        op_code  = op;
        op_mask  = m;
        op_data  = d;
        emu_mode = e;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_all("R1", 16'h0000, 8'h34, 1'b1, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].mask, VECS[i].data, VECS[i].emu);
            chk_all($sformatf("R%0d", VECS[i].rq), VECS[i].acc, VECS[i].st,
                    VECS[i].w, VECS[i].out);
        end

        // R4: emulation forcing with no operation issued
        issue(5'd1, 8'h20, 16'h0000, 1'b0);
        chk("R2", "status", {8'h00, status}, 16'h0000);
        emu_mode = 1'b1;
        @(negedge clk);
        chk("R4", "status idle emu", {8'h00, status}, 16'h0020);

        // R12: operands change but valid stays low
        emu_mode = 1'b0;
        op_code  = 5'd4;
        op_data  = 16'h0000;
        op_mask  = 8'hFF;
        repeat (3) @(negedge clk);
        chk_all("R12", 16'hA584, 8'h20, 1'b1, 16'h7FFF);

        // R11: flag changes back to back with a width-aware load
        issue(5'd1, 8'h20, 16'h0000, 1'b0);
        chk("R11", "width after clear", {15'd0, width_used}, 16'd1);
        issue(5'd2, 8'h20, 16'h0000, 1'b0);
        chk("R11", "width after set", {15'd0, width_used}, 16'd0);
        issue(5'd4, 8'h00, 16'h1234, 1'b0);
        chk("R11", "width of load", {15'd0, width_used}, 16'd1);
        chk("R5", "acc narrow load", acc, 16'hA534);
        chk("R6", "status", {8'h00, status}, 16'h0020);

        // R1: reset in mid-run
        rst_n = 1'b0;
        emu_mode = 1'b1;
        @(negedge clk);
        chk_all("R1", 16'h0000, 8'h34, 1'b1, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule